// File: doc/BRIEF.md
# Panel Power Sequencer

The block brings up an LCD panel and its backlight in a fixed order. A programmable gap in milliseconds precedes each step. The five rails come up in this order: panel logic supply, pixel data path, lamp supply, lamp PWM enable, and lamp on. A request to switch off takes them down again in the reverse order. A millisecond tick is made by dividing the system clock. Every gap is counted on that tick, so a software driver only writes five small numbers and pulses a request.

The five gap values are captured when a power-on request is taken. They then stay fixed until the sequence ends. A power-off request can arrive while power-up is still running. In that case the block stops climbing and unwinds from the highest rail it has raised. An LVDS link power-down output follows the data rail in the opposite sense. Two status outputs report a fully powered panel (`seq_ready`) and a fully dark panel (`seq_idle`).

Top module: `panel_pwr_seq`

## Requirements
- R1: While `rst_n` is low, all five rail outputs and `seq_ready` are 0, and `link_pd` and `seq_idle` are 1.
- R2: The rail outputs always form a thermometer, with bit order lcd_supply, pix_data, lamp_supply, lamp_pwm, lamp_on. A rail is only high when every rail before it is high.
- R3: One tick lasts P = CLK_HZ/TICK_HZ clock cycles. The tick divider restarts when a request is accepted. Take the edge that accepts power-on as cycle 0 and let g0..g4 be the five gaps. Rail k then rises at cycle P*sum over j=0..k of (g_j+1), so a gap of 0 costs exactly one tick. The internal gap counter never passes its gap.
- R4: `link_pd` falls on the same edge as `pix_data_en` rises, and rises again on the same edge as `pix_data_en` falls.
- R5: `seq_ready` rises P cycles after `lamp_on` rises. It is only high while all five rails are high.
- R6: Take the edge that accepts power-off as cycle 0. At that edge the highest raised rail falls. Once rail k has fallen, the block waits P*(g_k+1) cycles and then lowers rail k-1.
- R7: After `lcd_supply_en` falls, the block waits a further P*(g0+1) cycles and then raises `seq_idle`. It ignores `pwr_on_req` until then.
- R8: A power-off request during power-up, including the settling tick before ready, starts the unwind from the highest rail raised so far. If it wins a tie with a rising edge, that rail does not rise. If no rail has been raised yet, the block returns to idle on the accepting edge.
- R9: Gap inputs are sampled only on the edge that accepts power-on. Changes to them during a sequence have no effect on its timing.
- R10: `pwr_on_req` is accepted only in idle, and only when `pwr_off_req` is low. `pwr_off_req` is ignored while idle and while powering down.
- R11: At most one rail changes per clock cycle. A rail rises only on a tick boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on_req | input | 1 | Request to start power-up (sampled each cycle) |
| pwr_off_req | input | 1 | Request to start power-down (sampled each cycle) |
| gap_supply_ms | input | DLY_W | Gap before the panel logic supply rises; also the hold-off after it falls |
| gap_data_ms | input | DLY_W | Gap from logic supply up to data up; data down to supply down |
| gap_lamp_ms | input | DLY_W | Gap from data up to lamp supply up, and the reverse |
| gap_pwm_ms | input | DLY_W | Gap from lamp supply up to PWM enable up, and the reverse |
| gap_on_ms | input | DLY_W | Gap from PWM enable up to lamp on, and the reverse |
| lcd_supply_en | output | 1 | Panel logic supply enable |
| pix_data_en | output | 1 | Pixel data path enable |
| lamp_supply_en | output | 1 | Backlight supply enable |
| lamp_pwm_en | output | 1 | Backlight PWM enable |
| lamp_on | output | 1 | Backlight enable |
| link_pd | output | 1 | LVDS link power-down, active high |
| seq_ready | output | 1 | Panel fully powered |
| seq_idle | output | 1 | Panel fully dark, ready for a new request |

## Verification
The assertions check the shape of the outputs on every cycle: rails stay in thermometer order, only one rail moves per cycle, rises fall on tick boundaries, and ready and idle agree with the rails. They also check that the captured gaps hold still during a sequence and that the gap counter stays in range. Exact cycle positions of each rise and fall can only be shown by the bench's scenarios, which compare the ports every cycle against times computed from the gaps. The same goes for abort points (including a tie with a rising edge), ignored requests, and gap inputs that change mid-sequence.

// File: rtl/pps_pkg.sv
package pps_pkg;

  // Number of rails in the power chain; the order is part of the behaviour.
  localparam int unsigned NSTAGE = 5;
  localparam int unsigned LVL_W  = $clog2(NSTAGE + 1);

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_UP,
    SEQ_SETTLE,
    SEQ_ON,
    SEQ_DOWN
  } seq_state_t;

  // Clock cycles per millisecond tick, never below one.
  function automatic int unsigned ms_divisor(int unsigned clk_hz, int unsigned tick_hz);
    int unsigned q;
    q = clk_hz / tick_hz;
    return (q < 1) ? 1 : q;
  endfunction

  // Rails that are on for a given level: the lowest 'lvl' bits set.
  function automatic logic [NSTAGE-1:0] rail_therm(logic [LVL_W-1:0] lvl);
    logic [NSTAGE-1:0] r;
    for (int i = 0; i < NSTAGE; i++) r[i] = (LVL_W'(i) < lvl);
    return r;
  endfunction

endpackage

// File: rtl/pps_tick_gen.sv
module pps_tick_gen #(
  parameter int unsigned DIV = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PW-1:0] pre_q;

  assign tick = (pre_q == PW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           pre_q <= '0;
    else if (clr || tick) pre_q <= '0;
    else                  pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/pps_delay_cnt.sv
module pps_delay_cnt #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         expire,
  output logic [W-1:0] cnt_q
);
  // Gap g expires on the (g+1)-th tick after a clear.
  assign expire = run && tick && !clr && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (clr || expire)   cnt_q <= '0;
    else if (run && tick)     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pps_seq_ctrl.sv
module pps_seq_ctrl
  import pps_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             on_req,
  input  logic             off_req,
  input  logic             tick,
  input  logic             expire,
  output seq_state_t       state_q,
  output logic [LVL_W-1:0] idx_q,
  output logic [LVL_W-1:0] level_q,
  output logic             accept,
  output logic             take_on,
  output logic             run
);
  localparam logic [LVL_W-1:0] LAST = LVL_W'(NSTAGE - 1);

  logic take_off;

  assign take_on  = (state_q == SEQ_IDLE) && on_req && !off_req;
  assign take_off = off_req && ((state_q == SEQ_UP) || (state_q == SEQ_SETTLE) ||
                                (state_q == SEQ_ON));
  assign accept   = take_on || take_off;
  assign run      = (state_q == SEQ_UP) || (state_q == SEQ_DOWN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
      level_q <= '0;
    end else if (take_off) begin
      // Unwind from the highest rail raised so far.
      if (level_q == '0) begin
        state_q <= SEQ_IDLE;
        idx_q   <= '0;
      end else begin
        state_q <= SEQ_DOWN;
        level_q <= level_q - 1'b1;
        idx_q   <= level_q - 1'b1;
      end
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (take_on) begin
          state_q <= SEQ_UP;
          idx_q   <= '0;
        end
        SEQ_UP: if (expire) begin
          level_q <= level_q + 1'b1;
          if (idx_q == LAST) state_q <= SEQ_SETTLE;
          else               idx_q   <= idx_q + 1'b1;
        end
        SEQ_SETTLE: if (tick) state_q <= SEQ_ON;
        SEQ_ON: ;
        SEQ_DOWN: if (expire) begin
          if (idx_q == '0) begin
            state_q <= SEQ_IDLE;
          end else begin
            level_q <= level_q - 1'b1;
            idx_q   <= idx_q - 1'b1;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
  import pps_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 50_000_000,
  parameter int unsigned TICK_HZ = 1000,
  parameter int unsigned DLY_W   = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_on_req,
  input  logic             pwr_off_req,
  input  logic [DLY_W-1:0] gap_supply_ms,
  input  logic [DLY_W-1:0] gap_data_ms,
  input  logic [DLY_W-1:0] gap_lamp_ms,
  input  logic [DLY_W-1:0] gap_pwm_ms,
  input  logic [DLY_W-1:0] gap_on_ms,
  output logic             lcd_supply_en,
  output logic             pix_data_en,
  output logic             lamp_supply_en,
  output logic             lamp_pwm_en,
  output logic             lamp_on,
  output logic             link_pd,
  output logic             seq_ready,
  output logic             seq_idle
);
  localparam int unsigned DIV = ms_divisor(CLK_HZ, TICK_HZ);

  // Named internal events, brought out for the checker.
  logic                    tick_w;
  logic                    expire_w;
  logic                    accept_w;
  logic                    take_on_w;
  logic                    run_w;
  seq_state_t              state_w;
  logic [LVL_W-1:0]        idx_w;
  logic [LVL_W-1:0]        level_w;
  logic [DLY_W-1:0]        limit_w;
  logic [DLY_W-1:0]        cnt_w;
  logic [NSTAGE-1:0]       rails_w;
  logic [DLY_W-1:0]        gap_in [NSTAGE];
  logic [DLY_W-1:0]        gap_q  [NSTAGE];
  logic [NSTAGE*DLY_W-1:0] gap_flat;

  assign gap_in[0] = gap_supply_ms;
  assign gap_in[1] = gap_data_ms;
  assign gap_in[2] = gap_lamp_ms;
  assign gap_in[3] = gap_pwm_ms;
  assign gap_in[4] = gap_on_ms;

  // Gaps captured once, on the accepting edge of a power-on request.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSTAGE; i++) gap_q[i] <= '0;
    end else if (take_on_w) begin
      for (int i = 0; i < NSTAGE; i++) gap_q[i] <= gap_in[i];
    end
  end

  generate
    for (genvar g = 0; g < NSTAGE; g++) begin : g_flat
      assign gap_flat[g*DLY_W +: DLY_W] = gap_q[g];
    end
  endgenerate

  always_comb begin
    limit_w = '0;
    for (int i = 0; i < NSTAGE; i++)
      if (idx_w == LVL_W'(i)) limit_w = gap_q[i];
  end

  pps_tick_gen #(.DIV(DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept_w),
    .tick  (tick_w)
  );

  pps_delay_cnt #(.W(DLY_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (accept_w),
    .run    (run_w),
    .tick   (tick_w),
    .limit  (limit_w),
    .expire (expire_w),
    .cnt_q  (cnt_w)
  );

  pps_seq_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .on_req  (pwr_on_req),
    .off_req (pwr_off_req),
    .tick    (tick_w),
    .expire  (expire_w),
    .state_q (state_w),
    .idx_q   (idx_w),
    .level_q (level_w),
    .accept  (accept_w),
    .take_on (take_on_w),
    .run     (run_w)
  );

  assign rails_w        = rail_therm(level_w);
  assign lcd_supply_en  = rails_w[0];
  assign pix_data_en    = rails_w[1];
  assign lamp_supply_en = rails_w[2];
  assign lamp_pwm_en    = rails_w[3];
  assign lamp_on        = rails_w[4];
  assign link_pd        = ~rails_w[1];
  assign seq_ready      = (state_w == SEQ_ON);
  assign seq_idle       = (state_w == SEQ_IDLE);
endmodule

// File: rtl/pps_seq_chk.sv
module pps_seq_chk #(
  parameter int unsigned N = 5,
  parameter int unsigned W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] rails,
  input logic         ready,
  input logic         idle,
  input logic         tick,
  input logic [W-1:0] cnt,
  input logic [W-1:0] limit,
  input logic [N*W-1:0] gaps
);
  assert_rail_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, rails} & ({1'b0, rails} + 1'b1)) == '0);

  assert_one_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rails ^ $past(rails)) <= 1);

  assert_rise_on_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rails & ~$past(rails))) |-> $past(tick));

  assert_ready_late_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> ($past(tick) && rails[N-1] && $past(rails[N-1])));

  assert_ready_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (&rails));

  assert_idle_dark_R7: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (rails == '0));

  assert_gap_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && $past(!idle)) |-> $stable(gaps));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= limit);
endmodule

bind panel_pwr_seq pps_seq_chk #(.N(pps_pkg::NSTAGE), .W(DLY_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .rails (rails_w),
  .ready (seq_ready),
  .idle  (seq_idle),
  .tick  (tick_w),
  .cnt   (cnt_w),
  .limit (limit_w),
  .gaps  (gap_flat)
);

// File: tb/panel_pwr_seq_tb_top.sv
module panel_pwr_seq_tb_top;
  localparam int unsigned CLK_HZ = 8000;
  localparam int unsigned P      = CLK_HZ / 1000;
  localparam int unsigned W      = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic on_req = 1'b0;
  logic off_req = 1'b0;
  logic [W-1:0] gin [5];
  logic lcd_supply_en, pix_data_en, lamp_supply_en, lamp_pwm_en, lamp_on;
  logic link_pd, seq_ready, seq_idle;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  int d [5];

  always #5 clk = ~clk;

  panel_pwr_seq #(.CLK_HZ(CLK_HZ), .TICK_HZ(1000), .DLY_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_on_req(on_req), .pwr_off_req(off_req),
    .gap_supply_ms(gin[0]), .gap_data_ms(gin[1]), .gap_lamp_ms(gin[2]),
    .gap_pwm_ms(gin[3]), .gap_on_ms(gin[4]),
    .lcd_supply_en(lcd_supply_en), .pix_data_en(pix_data_en),
    .lamp_supply_en(lamp_supply_en), .lamp_pwm_en(lamp_pwm_en), .lamp_on(lamp_on),
    .link_pd(link_pd), .seq_ready(seq_ready), .seq_idle(seq_idle)
  );

  // Cycle of rail k rising, counted from the accepting edge (R3).
  function automatic int up_rise(int k);
    int s = 0;
    for (int j = 0; j <= k; j++) s += (d[j] + 1) * P;
    return s;
  endfunction

  function automatic int up_level(int t);
    int n = 0;
    for (int k = 0; k < 5; k++) if (up_rise(k) <= t) n++;
    return n;
  endfunction

  // Cycle of rail j falling when the unwind starts at level L (R6).
  function automatic int dn_fall(int j, int L);
    int s = 0;
    for (int m = j + 1; m < L; m++) s += (d[m] + 1) * P;
    return s;
  endfunction

  function automatic int dn_idle(int L);
    int s = 0;
    for (int m = 0; m < L; m++) s += (d[m] + 1) * P;
    return s;
  endfunction

  function automatic int dn_level(int t, int L);
    int n = L;
    for (int j = 0; j < L; j++) if (dn_fall(j, L) <= t) n--;
    return n;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic chk(string tag, int lvl, bit rdy, bit idl);
    logic [4:0] er;
    logic [4:0] got;
    for (int k = 0; k < 5; k++) er[k] = (k < lvl);
    got = {lamp_on, lamp_pwm_en, lamp_supply_en, pix_data_en, lcd_supply_en};
    n_chk++;
    if (got !== er || link_pd !== !er[1] || seq_ready !== rdy || seq_idle !== idl) begin
      n_bad++;
      $display("FAIL %s @%0t: actual rails=%b pd=%b rdy=%b idle=%b, expected rails=%b pd=%b rdy=%b idle=%b",
               tag, $time, got, link_pd, seq_ready, seq_idle, er, !er[1], rdy, idl);
    end
  endtask

  task automatic set_gaps(int a, int b, int c, int e, int f);
    d[0] = a; d[1] = b; d[2] = c; d[3] = e; d[4] = f;
    for (int k = 0; k < 5; k++) gin[k] = W'(d[k]);
  endtask

  // Power up; abort_t < 0 runs to ready. Returns the level reached.
  task automatic run_up(int abort_t, output int L);
    int tr;
    tr = up_rise(4) + P;
    @(negedge clk) on_req = 1'b1;
    @(negedge clk) on_req = 1'b0;
    for (int t = 0; ; t++) begin
      if (t > 0) @(negedge clk);
      chk("R2 R3 R4 R5 R9 R10", up_level(t), t >= tr, 1'b0);
      if (t == 1) for (int k = 0; k < 5; k++) gin[k] = W'($urandom % 9);  // R9
      if (t == 2) on_req = 1'b1;                                          // R10
      if (t == 3) on_req = 1'b0;
      if (t == abort_t || t == tr + 2) begin
        off_req = 1'b1;
        L = up_level(t);                                                  // R8
        @(negedge clk);
        off_req = 1'b0;
        on_req  = 1'b0;
        break;
      end
    end
  endtask

  // Called at the negedge right after the power-off accepting edge.
  task automatic run_down(int L);
    int ti;
    ti = dn_idle(L);
    for (int t = 0; t <= ti + 2; t++) begin
      if (t > 0) @(negedge clk);
      chk("R6 R7 R8 R10", dn_level(t, L), 1'b0, t >= ti);
      if (L > 0) begin
        if (t == 1) on_req  = 1'b1;   // R7: ignored while unwinding
        if (t == 2) on_req  = 1'b0;
        if (t == 3) off_req = 1'b1;   // R10: ignored while unwinding
        if (t == 4) off_req = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R3 watchdog: actual run still busy, expected completion");
    finish_run();
  end

  initial begin
    int L;
    void'($urandom(32'd7341));
    set_gaps(0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    chk("R1", 0, 1'b0, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", 0, 1'b0, 1'b1);

    // R10: off request in idle, and both requests together, leave it idle.
    off_req = 1'b1;
    @(negedge clk) off_req = 1'b0;
    for (int i = 0; i < 3; i++) begin @(negedge clk); chk("R10", 0, 1'b0, 1'b1); end
    on_req = 1'b1; off_req = 1'b1;
    @(negedge clk) begin on_req = 1'b0; off_req = 1'b0; end
    for (int i = 0; i < 3; i++) begin @(negedge clk); chk("R10", 0, 1'b0, 1'b1); end

    // Directed: scaled typical gaps, full cycle.
    set_gaps(4, 0, 3, 1, 2);
    run_up(-1, L); run_down(L);
    // R3 corner: every gap zero.
    set_gaps(0, 0, 0, 0, 0);
    run_up(-1, L); run_down(L);
    // R8: abort before any rail rises.
    set_gaps(2, 1, 1, 1, 1);
    run_up(0, L); run_down(L);
    // R8: abort on the very edge where rail 2 would rise.
    set_gaps(1, 2, 3, 0, 1);
    run_up(up_rise(2) - 1, L); run_down(L);
    // R8: abort during the settling tick before ready.
    set_gaps(0, 1, 0, 1, 0);
    run_up(up_rise(4) + 2, L); run_down(L);

    // Random mix of full runs and aborts.
    for (int it = 0; it < 25; it++) begin
      int ab;
      set_gaps($urandom % 8, $urandom % 8, $urandom % 8, $urandom % 8, $urandom % 8);
      ab = (($urandom % 3) == 0) ? -1 : int'($urandom % (up_rise(4) + P + 2));
      run_up(ab, L);
      run_down(L);
    end
    finish_run();
  end
endmodule